// File: doc/BRIEF.md
# Handshake Channel Phase and Stall Monitor

This block watches one valid/ready channel without taking part in it. The channel is a point-to-point link. The sender raises `ch_valid` with a word on `ch_data`. The receiver raises `ch_ready` when it can take the word. A word moves in every cycle in which both are high. The monitor drives nothing back into the channel, so it never applies back-pressure. Back-pressure is the receiver holding `ch_ready` low. The sender must then keep `ch_valid` high and keep `ch_data` unchanged until a transfer happens. A receiver that raises `ch_ready` first must keep it high until a word arrives.

In every cycle the monitor labels the channel with one of four phases. It flags each break of the retry rules one cycle after it happens. It also runs two saturating run-length counters: one for stalls, where a word is offered and not taken, and one for an absent sender. When a counter reaches its threshold it raises a status level. A stall that stays past its threshold while the sender is still offering a word is reported as a suspected deadlock. This gives a bounded, cycle-counted stand-in for the condition "offered but never accepted". A long quiet period with no offer is not counted as a deadlock.

Top module: `hs_channel_monitor`

## Requirements
- R1: `phase` is `{ch_valid, ch_ready}` in the same cycle, with no register in the path. The codes are 2'b00 inactive, 2'b01 receiver waiting (backward retry), 2'b10 sender waiting (forward retry) and 2'b11 transfer.
- R2: `xfer` is high in exactly the cycles in which `ch_valid` and `ch_ready` are both high, so each accepted word gives one strobe cycle.
- R3: A sampled cycle in phase 2'b10 may be followed only by phase 2'b10 or phase 2'b11. Any other next phase raises `fwd_exit_err` for one cycle, in the cycle after the offending sample.
- R4: A sampled cycle in phase 2'b01 may be followed only by phase 2'b01 or phase 2'b11. Any other next phase raises `bwd_exit_err` for one cycle, in the cycle after the offending sample.
- R5: `data_err` pulses for one cycle, in the cycle after a sample, when that sample has `ch_valid` high and `ch_data` differs from its value in the cycle before, and that cycle before was in phase 2'b10.
- R6: `block_flag` rises in the cycle after the BLOCK_LIMIT-th consecutive sample in phase 2'b10. It stays high through any longer run, because the counter saturates and does not wrap. It clears in the cycle after any other sample, including a transfer.
- R7: `idle_flag` rises in the cycle after the IDLE_LIMIT-th consecutive sample with `ch_valid` low, in either phase 2'b00 or phase 2'b01. It stays high through any longer run. It clears in the cycle after a sample with `ch_valid` high.
- R8: `deadlock_flag` equals `block_flag` AND NOT `idle_flag`. It is low during a long idle run.
- R9: While `rst_n` is low, `fwd_exit_err`, `bwd_exit_err`, `data_err`, `block_flag`, `idle_flag` and `deadlock_flag` are all low. The first sample after reset is never treated as a retry exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | 1 | Observed sender valid |
| ch_ready | input | 1 | Observed receiver ready |
| ch_data | input | DATA_W | Observed channel word |
| phase | output | 2 | Current phase code {valid, ready} |
| xfer | output | 1 | Word accepted this cycle |
| fwd_exit_err | output | 1 | Sender left a wait without a transfer |
| bwd_exit_err | output | 1 | Receiver left a wait without a transfer |
| data_err | output | 1 | Word changed while the sender was waiting |
| block_flag | output | 1 | Stall run has reached BLOCK_LIMIT |
| idle_flag | output | 1 | Absent-sender run has reached IDLE_LIMIT |
| deadlock_flag | output | 1 | Blocked and not idle |

## Verification
Most faults in the stored state show up at the ports one cycle after the first affected sample. A wrong stored phase makes an error pulse appear after a legal sequence, or go missing after an illegal one. A stored word that fails to update makes `data_err` fire while the word is in fact held steady. A run counter that misses a step, fails to clear or wraps shows up as `block_flag` or `idle_flag` rising one cycle early or late at the threshold. It also shows up as the flag dropping during a run much longer than the limit, or staying high after a transfer. The checks for these sit exactly at the threshold cycle and at the cycle after the run ends.

// File: rtl/hs_chmon_pkg.sv
package hs_chmon_pkg;

  typedef enum logic [1:0] {
    PH_INACTIVE = 2'b00,
    PH_BWD_WAIT = 2'b01,
    PH_FWD_WAIT = 2'b10,
    PH_XFER     = 2'b11
  } hs_phase_e;

  function automatic logic is_wait(input hs_phase_e p);
    return (p == PH_BWD_WAIT) || (p == PH_FWD_WAIT);
  endfunction

endpackage

// File: rtl/hs_chmon_classify.sv
module hs_chmon_classify
  import hs_chmon_pkg::*;
(
  input  logic      valid_i,
  input  logic      ready_i,
  output hs_phase_e phase_o,
  output logic      xfer_o
);

  always_comb begin
    unique case ({valid_i, ready_i})
      2'b11:   phase_o = PH_XFER;
      2'b10:   phase_o = PH_FWD_WAIT;
      2'b01:   phase_o = PH_BWD_WAIT;
      default: phase_o = PH_INACTIVE;
    endcase
  end

  assign xfer_o = (phase_o == PH_XFER);

endmodule

// File: rtl/hs_chmon_retry.sv
module hs_chmon_retry
  import hs_chmon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hs_phase_e         phase_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              fwd_err_o,
  output logic              bwd_err_o,
  output logic              data_err_o
);

  hs_phase_e         last_phase;
  logic [DATA_W-1:0] last_data;
  logic              left_wait;
  logic              word_moved;

  // a wait phase may only persist or resolve into a transfer
  assign left_wait  = is_wait(last_phase) && (phase_i != last_phase) &&
                      (phase_i != PH_XFER);
  assign word_moved = (last_phase == PH_FWD_WAIT) && phase_i[1] &&
                      (data_i != last_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_phase <= PH_INACTIVE;
      last_data  <= '0;
      fwd_err_o  <= 1'b0;
      bwd_err_o  <= 1'b0;
      data_err_o <= 1'b0;
    end else begin
      last_phase <= phase_i;
      last_data  <= data_i;
      fwd_err_o  <= left_wait && (last_phase == PH_FWD_WAIT);
      bwd_err_o  <= left_wait && (last_phase == PH_BWD_WAIT);
      data_err_o <= word_moved;
    end
  end

  AST_FWD_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_err_o |-> ($past(phase_i) != PH_XFER && $past(phase_i) != PH_FWD_WAIT)); // R3

  AST_BWD_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bwd_err_o |-> ($past(phase_i) != PH_XFER && $past(phase_i) != PH_BWD_WAIT)); // R4

  AST_EXIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_err_o, bwd_err_o})); // R3

  AST_DATA_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    data_err_o |-> $past(phase_i[1])); // R5

endmodule

// File: rtl/hs_chmon_runlen.sv
module hs_chmon_runlen #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  output logic flag_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!hit_i) begin
      run_q <= '0;
    end else if (run_q != TOP) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign flag_o = (run_q == TOP);

  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i |=> (run_q == '0)); // R6

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && run_q != TOP) |=> (run_q == $past(run_q) + 1'b1)); // R6

  AST_RUN_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && run_q == TOP) |=> (run_q == TOP)); // R6

endmodule

// File: rtl/hs_channel_monitor.sv
module hs_channel_monitor
  import hs_chmon_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BLOCK_LIMIT = 8,
  parameter int IDLE_LIMIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_valid,
  input  logic              ch_ready,
  input  logic [DATA_W-1:0] ch_data,
  output logic [1:0]        phase,
  output logic              xfer,
  output logic              fwd_exit_err,
  output logic              bwd_exit_err,
  output logic              data_err,
  output logic              block_flag,
  output logic              idle_flag,
  output logic              deadlock_flag
);

  localparam int NRUN = 2;

  hs_phase_e        cur_phase;
  logic [NRUN-1:0]  run_hit;
  logic [NRUN-1:0]  run_flag;

  hs_chmon_classify u_cls (
    .valid_i (ch_valid),
    .ready_i (ch_ready),
    .phase_o (cur_phase),
    .xfer_o  (xfer)
  );

  hs_chmon_retry #(.DATA_W(DATA_W)) u_rty (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_i    (cur_phase),
    .data_i     (ch_data),
    .fwd_err_o  (fwd_exit_err),
    .bwd_err_o  (bwd_exit_err),
    .data_err_o (data_err)
  );

  // index 0 tracks stalls, index 1 tracks an absent sender
  assign run_hit[0] = (cur_phase == PH_FWD_WAIT);
  assign run_hit[1] = !cur_phase[1];

  for (genvar g = 0; g < NRUN; g++) begin : g_run
    localparam int LIM = (g == 0) ? BLOCK_LIMIT : IDLE_LIMIT;
    hs_chmon_runlen #(.LIMIT(LIM)) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (run_hit[g]),
      .flag_o (run_flag[g])
    );
  end

  assign phase         = cur_phase;
  assign block_flag    = run_flag[0];
  assign idle_flag     = run_flag[1];
  assign deadlock_flag = block_flag && !idle_flag;

  AST_BLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    block_flag |-> $past(ch_valid && !ch_ready)); // R6

  AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_flag |-> $past(!ch_valid)); // R7

  AST_BLOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !block_flag); // R6

endmodule

// File: tb/sim_hs_channel_monitor.sv
module sim_hs_channel_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int BLK = 8;
  localparam int IDL = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ch_valid = 1'b0;
  logic       ch_ready = 1'b0;
  logic [7:0] ch_data = 8'h00;
  logic [1:0] phase;
  logic       xfer, fwd_exit_err, bwd_exit_err, data_err;
  logic       block_flag, idle_flag, deadlock_flag;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_channel_monitor #(.DATA_W(8), .BLOCK_LIMIT(BLK), .IDLE_LIMIT(IDL)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_ready(ch_ready),
    .ch_data(ch_data), .phase(phase), .xfer(xfer),
    .fwd_exit_err(fwd_exit_err), .bwd_exit_err(bwd_exit_err),
    .data_err(data_err), .block_flag(block_flag), .idle_flag(idle_flag),
    .deadlock_flag(deadlock_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply one cycle; on return the registered outputs reflect it
  task automatic drive(input logic v, input logic r, input logic [7:0] d);
    ch_valid = v; ch_ready = r; ch_data = d;
    #1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_errs(input string req, input logic f, input logic b, input logic de);
    chk({req, " fwd_exit_err"}, {7'd0, fwd_exit_err}, {7'd0, f});
    chk({req, " bwd_exit_err"}, {7'd0, bwd_exit_err}, {7'd0, b});
    chk({req, " data_err"}, {7'd0, data_err}, {7'd0, de});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ch_valid = 1'b1; ch_ready = 1'b0;
    repeat (12) @(negedge clk);
    chk("R9 block in reset", {7'd0, block_flag}, 8'd0);
    chk("R9 deadlock in reset", {7'd0, deadlock_flag}, 8'd0);
    chk("R9 idle in reset", {7'd0, idle_flag}, 8'd0);
    chk_errs("R9 reset", 1'b0, 1'b0, 1'b0);
    ch_valid = 1'b0;
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 8'h11);
    chk_errs("R9 first sample", 1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 8'h11);
  endtask

  task automatic t_phase();
    for (int k = 0; k < 4; k++) begin
      ch_valid = k[1]; ch_ready = k[0]; ch_data = 8'h11;
      #1;
      chk("R1 phase code", {6'd0, phase}, k[7:0]);
      chk("R2 xfer strobe", {7'd0, xfer}, {7'd0, k == 3});
      @(negedge clk);
    end
    drive(1'b1, 1'b1, 8'h11);
  endtask

  task automatic t_fwd();
    drive(1'b1, 1'b0, 8'h22);
    drive(1'b1, 1'b0, 8'h22);
    drive(1'b1, 1'b1, 8'h22);
    chk_errs("R3 wait then transfer", 1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 8'h23);
    drive(1'b0, 1'b0, 8'h23);
    chk_errs("R3 wait dropped", 1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 8'h23);
    chk_errs("R3 pulse one cycle", 1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 8'h23);
    drive(1'b0, 1'b1, 8'h23);
    chk_errs("R3 wait to receiver wait", 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 8'h23);
    chk_errs("R4 receiver wait then transfer", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_bwd();
    drive(1'b0, 1'b1, 8'h30);
    drive(1'b0, 1'b1, 8'h30);
    chk_errs("R4 receiver wait held", 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 8'h30);
    chk_errs("R4 ready withdrawn", 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 8'h30);
    drive(1'b1, 1'b0, 8'h30);
    chk_errs("R4 receiver wait to sender wait", 1'b0, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 8'h30);
  endtask

  task automatic t_data();
    drive(1'b1, 1'b0, 8'h40);
    drive(1'b1, 1'b0, 8'h40);
    chk_errs("R5 held word", 1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 8'h41);
    chk_errs("R5 changed in wait", 1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 8'h41);
    chk_errs("R5 steady into transfer", 1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 8'h50);
    drive(1'b1, 1'b1, 8'h51);
    chk_errs("R5 changed at transfer", 1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 8'h52);
    chk_errs("R5 change after transfer ok", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_block();
    for (int k = 0; k < BLK - 1; k++) drive(1'b1, 1'b0, 8'h60);
    chk("R6 block below limit", {7'd0, block_flag}, 8'd0);
    chk("R8 deadlock below limit", {7'd0, deadlock_flag}, 8'd0);
    drive(1'b1, 1'b0, 8'h60);
    chk("R6 block at limit", {7'd0, block_flag}, 8'd1);
    chk("R8 deadlock at limit", {7'd0, deadlock_flag}, 8'd1);
    chk("R7 idle during stall", {7'd0, idle_flag}, 8'd0);
    for (int k = 0; k < 40; k++) drive(1'b1, 1'b0, 8'h60);
    chk("R6 block saturates", {7'd0, block_flag}, 8'd1);
    drive(1'b1, 1'b1, 8'h60);
    chk("R6 block cleared by transfer", {7'd0, block_flag}, 8'd0);
    chk("R8 deadlock cleared", {7'd0, deadlock_flag}, 8'd0);
  endtask

  task automatic t_idle();
    for (int k = 0; k < IDL - 1; k++) drive(1'b0, k[0], 8'h70);
    chk("R7 idle below limit", {7'd0, idle_flag}, 8'd0);
    drive(1'b0, 1'b1, 8'h70);
    chk("R7 idle at limit", {7'd0, idle_flag}, 8'd1);
    chk("R8 no deadlock while idle", {7'd0, deadlock_flag}, 8'd0);
    for (int k = 0; k < 20; k++) drive(1'b0, 1'b1, 8'h70);
    chk("R7 idle saturates", {7'd0, idle_flag}, 8'd1);
    drive(1'b1, 1'b1, 8'h70);
    chk("R7 idle cleared by offer", {7'd0, idle_flag}, 8'd0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_phase();
        t_fwd();
        t_bwd();
        t_data();
        t_block();
        t_idle();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule